// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register file and pad-control logic of a 16-pin general-purpose I/O port. A host reaches it over a small synchronous register bus (byte address, byte write data, write and read strobes, registered read data). Each per-pin setting is one bit per pin, spread over two byte registers: the lower pins sit at the base address and the upper pins at the address one below it. The stored settings are pad direction, output latch, pull-up enable, pull-down enable, open-drain enable and input inversion. A spare byte-wide miscellaneous register is also held.

The pads appear as plain vectors: drive value, output enable and the two pull controls, plus the raw pad inputs, which pass through a synchronizer before software sees them. Reading the data register returns the pin view: the synchronized, optionally inverted level of input pins and the latch value of output pins. Writing a two-byte key to one dedicated address returns every register to its default without the hardware reset.

Top module: `gpx_port_regs`

## Requirements
- R1: Each per-pin setting with base address N keeps pins 7..0 in the byte at N and pins 15..8 in the byte at N-1; the bases are pull-up 0x07, pull-down 0x09, open-drain 0x0B, inversion 0x0D, direction 0x0F and data 0x11, and every setting byte except the data bytes reads back the value last written.
- R2: After the hardware reset the direction bytes read 0xFF, every other register reads 0x00, bus_rdata is 0x00 and no pad is driven.
- R3: pad_pu and pad_pd equal, bit for bit, the pull-up and pull-down settings.
- R4: A direction bit of 1 makes its pin an input (pad_oe low); a direction bit of 0 makes it an output with pad_oe high and pad_out equal to its latch bit, unless open-drain is set for that pin.
- R5: With the open-drain bit set, pad_out is 0 and an output pin is driven only while its latch bit is 0; a latch bit of 1 releases it (pad_oe low).
- R6: A read of a data byte returns, per pin, the synchronized pad_in XOR the inversion bit when the pin is an input and the latch bit when it is an output; a pad_in change is visible to a read whose strobe is sampled SYNC_STAGES edges later.
- R7: bus_rdata takes the addressed value at the clock edge that samples bus_rd and holds it while bus_rd is low.
- R8: The miscellaneous byte at 0x1F stores any written value (for example 0x01), reads it back and resets to 0x00.
- R9: A write of 0x12 to 0x7D followed, as the very next write (idle cycles allowed), by a write of 0x34 to 0x7D returns all registers to their reset defaults at that edge.
- R10: A wrong second key value, or any other write between the two key writes, cancels the key with no reset; that intervening write still takes effect.
- R11: Reads of any address outside the listed registers return 0x00, and writes to them change no register or pad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one write per sampled cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Pad drive value |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pu | output | NUM_PINS | Pad pull-up enable |
| pad_pd | output | NUM_PINS | Pad pull-down enable |

## Verification
Register writes and the key reset take effect at the edge that samples the write strobe, so pad vectors are compared at the falling edge right after that write. Read data is due one edge after the read strobe and is sampled at the following falling edge; a pad input change is read back only after SYNC_STAGES further edges, and the bench waits that many edges before issuing the read. Holding of bus_rdata is checked several idle cycles after a read with the address moved elsewhere.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   // Low-byte (pins 7..0) addresses of the per-pin settings
   localparam logic [7:0] GPX_A_PULLUP  = 8'h07;
   localparam logic [7:0] GPX_A_PULLDN  = 8'h09;
   localparam logic [7:0] GPX_A_ODRAIN  = 8'h0B;
   localparam logic [7:0] GPX_A_INVERT  = 8'h0D;
   localparam logic [7:0] GPX_A_DIR     = 8'h0F;
   localparam logic [7:0] GPX_A_DATA    = 8'h11;
   localparam logic [7:0] GPX_A_MISC    = 8'h1F;
   // Software reset key
   localparam logic [7:0] GPX_A_KEY     = 8'h7D;
   localparam logic [7:0] GPX_KEY_FIRST = 8'h12;
   localparam logic [7:0] GPX_KEY_LAST  = 8'h34;

   typedef enum logic {
      KEY_IDLE  = 1'b0,
      KEY_ARMED = 1'b1
   } gpx_key_e;
endpackage

// File: rtl/gpx_bank_reg.sv
// One per-pin setting stored as NUM_PINS/8 bytes; byte k lives at BASE-k.
module gpx_bank_reg #(
   parameter int unsigned         NUM_PINS = 16,
   parameter logic [7:0]          BASE     = 8'h0F,
   parameter logic [NUM_PINS-1:0] RST_VAL  = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic                wr_en,
   input  logic [7:0]          addr,
   input  logic [7:0]          wdata,
   output logic [NUM_PINS-1:0] q
);
   localparam int unsigned NBYTES = NUM_PINS / 8;

   if (NUM_PINS % 8 != 0 || NUM_PINS == 0) begin : g_bad_width
      $error("gpx_bank_reg: NUM_PINS must be a non-zero multiple of 8");
   end

   for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      localparam logic [7:0] BYTE_ADDR = 8'(BASE - k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[8*k +: 8] <= RST_VAL[8*k +: 8];
         else if (soft_rst)
            q[8*k +: 8] <= RST_VAL[8*k +: 8];
         else if (wr_en && addr == BYTE_ADDR)
            q[8*k +: 8] <= wdata;
      end
   end
endmodule

// File: rtl/gpx_key_detect.sv
// Two-write key sequence; the second write must be the next write seen.
module gpx_key_detect
   import gpx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] addr,
   input  logic [7:0] wdata,
   output logic       soft_rst
);
   gpx_key_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= KEY_IDLE;
      else if (wr_en)
         state_q <= (addr == GPX_A_KEY && wdata == GPX_KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
   end

   assign soft_rst = (state_q == KEY_ARMED) && wr_en &&
                     (addr == GPX_A_KEY) && (wdata == GPX_KEY_LAST);
endmodule

// File: rtl/gpx_pin_sync.sv
module gpx_pin_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("gpx_pin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= '0;
         else if (s == 0)
            chain[s] <= d;
         else
            chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
   import gpx_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [7:0]          bus_addr,
   input  logic [7:0]          bus_wdata,
   input  logic                bus_wr,
   input  logic                bus_rd,
   output logic [7:0]          bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu,
   output logic [NUM_PINS-1:0] pad_pd
);
   localparam int unsigned NBYTES = NUM_PINS / 8;

   if (NUM_PINS != 8 && NUM_PINS != 16) begin : g_bad_pins
      $error("gpx_port_regs: NUM_PINS must be 8 or 16 to fit the address map");
   end

   logic                soft_rst;
   logic [NUM_PINS-1:0] pu_q, pd_q, od_q, inv_q, dir_q, lat_q;
   logic [NUM_PINS-1:0] pin_sync, pin_view;
   logic [7:0]          misc_q;
   logic [7:0]          rd_byte;

   gpx_key_detect u_key (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .soft_rst(soft_rst)
   );

   gpx_bank_reg #(.NUM_PINS(NUM_PINS), .BASE(GPX_A_PULLUP)) u_pu (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(bus_wr),
      .addr(bus_addr), .wdata(bus_wdata), .q(pu_q));
   gpx_bank_reg #(.NUM_PINS(NUM_PINS), .BASE(GPX_A_PULLDN)) u_pd (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(bus_wr),
      .addr(bus_addr), .wdata(bus_wdata), .q(pd_q));
   gpx_bank_reg #(.NUM_PINS(NUM_PINS), .BASE(GPX_A_ODRAIN)) u_od (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(bus_wr),
      .addr(bus_addr), .wdata(bus_wdata), .q(od_q));
   gpx_bank_reg #(.NUM_PINS(NUM_PINS), .BASE(GPX_A_INVERT)) u_inv (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(bus_wr),
      .addr(bus_addr), .wdata(bus_wdata), .q(inv_q));
   gpx_bank_reg #(.NUM_PINS(NUM_PINS), .BASE(GPX_A_DIR), .RST_VAL({NUM_PINS{1'b1}})) u_dir (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(bus_wr),
      .addr(bus_addr), .wdata(bus_wdata), .q(dir_q));
   gpx_bank_reg #(.NUM_PINS(NUM_PINS), .BASE(GPX_A_DATA)) u_lat (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(bus_wr),
      .addr(bus_addr), .wdata(bus_wdata), .q(lat_q));
   gpx_bank_reg #(.NUM_PINS(8), .BASE(GPX_A_MISC)) u_misc (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(bus_wr),
      .addr(bus_addr), .wdata(bus_wdata), .q(misc_q));

   gpx_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assign pad_out[i]  = od_q[i] ? 1'b0 : lat_q[i];
      assign pad_oe[i]   = ~dir_q[i] & ~(od_q[i] & lat_q[i]);
      assign pin_view[i] = dir_q[i] ? (pin_sync[i] ^ inv_q[i]) : lat_q[i];
   end

   assign pad_pu = pu_q;
   assign pad_pd = pd_q;

   always_comb begin
      rd_byte = '0;
      for (int k = 0; k < NBYTES; k++) begin
         if (bus_addr == 8'(GPX_A_PULLUP - k)) rd_byte = pu_q[8*k +: 8];
         if (bus_addr == 8'(GPX_A_PULLDN - k)) rd_byte = pd_q[8*k +: 8];
         if (bus_addr == 8'(GPX_A_ODRAIN - k)) rd_byte = od_q[8*k +: 8];
         if (bus_addr == 8'(GPX_A_INVERT - k)) rd_byte = inv_q[8*k +: 8];
         if (bus_addr == 8'(GPX_A_DIR    - k)) rd_byte = dir_q[8*k +: 8];
         if (bus_addr == 8'(GPX_A_DATA   - k)) rd_byte = pin_view[8*k +: 8];
      end
      if (bus_addr == GPX_A_MISC) rd_byte = misc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= rd_byte;
   end
endmodule

// File: rtl/gpx_port_regs_chk.sv
module gpx_port_regs_chk
   import gpx_pkg::*;
#(
   parameter int unsigned NUM_PINS = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [7:0]          bus_addr,
   input logic [7:0]          bus_wdata,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [7:0]          bus_rdata,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_pu,
   input logic [NUM_PINS-1:0] pad_pd,
   input logic [NUM_PINS-1:0] od_q,
   input logic                soft_rst
);
   localparam int unsigned NBYTES = NUM_PINS / 8;

   function automatic logic is_mapped(input logic [7:0] a);
      logic m;
      m = (a == GPX_A_MISC);
      for (int k = 0; k < NBYTES; k++) begin
         if (a == 8'(GPX_A_PULLUP - k) || a == 8'(GPX_A_PULLDN - k) ||
             a == 8'(GPX_A_ODRAIN - k) || a == 8'(GPX_A_INVERT - k) ||
             a == 8'(GPX_A_DIR - k)    || a == 8'(GPX_A_DATA - k))
            m = 1'b1;
      end
      return m;
   endfunction

   AST_PULLUP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == GPX_A_PULLUP) |=> pad_pu[7:0] == $past(bus_wdata)); // R3

   AST_DIR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == GPX_A_DIR && bus_wdata == 8'hFF) |=> pad_oe[7:0] == 8'h00); // R4

   AST_OD_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == GPX_A_DATA && bus_wdata == 8'hFF && od_q[7:0] == 8'hFF)
      |=> pad_oe[7:0] == 8'h00); // R5

   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R7

   AST_KEY_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0)); // R9

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !is_mapped(bus_addr)) |=> bus_rdata == 8'h00); // R11
endmodule

bind gpx_port_regs gpx_port_regs_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
   .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
   .od_q(od_q), .soft_rst(soft_rst)
);

// File: tb/gpx_port_regs_tb_top.sv
`timescale 1ns/1ps
module gpx_port_regs_tb_top;
   localparam int NP   = 16;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    addr = '0, wdata = '0;
   logic          wr = 1'b0, rd = 1'b0;
   logic [7:0]    rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd;

   int ncmp = 0;
   int nfail = 0;

   // expected state, built from the requirements
   logic [15:0] m_pu, m_pd, m_od, m_inv, m_dir, m_lat;
   logic [7:0]  m_misc;

   always #2.5 clk = ~clk;

   gpx_port_regs #(.NUM_PINS(NP), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
      .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd));

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      ncmp++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_defaults();
      m_pu = '0; m_pd = '0; m_od = '0; m_inv = '0; m_dir = 16'hFFFF; m_lat = '0; m_misc = '0;
   endtask

   // R1 address map: low byte at base, high byte at base-1
   task automatic model_wr(input logic [7:0] a, input logic [7:0] v);
      case (a)
         8'h07: m_pu[7:0]   = v;  8'h06: m_pu[15:8]  = v;
         8'h09: m_pd[7:0]   = v;  8'h08: m_pd[15:8]  = v;
         8'h0B: m_od[7:0]   = v;  8'h0A: m_od[15:8]  = v;
         8'h0D: m_inv[7:0]  = v;  8'h0C: m_inv[15:8] = v;
         8'h0F: m_dir[7:0]  = v;  8'h0E: m_dir[15:8] = v;
         8'h11: m_lat[7:0]  = v;  8'h10: m_lat[15:8] = v;
         8'h1F: m_misc      = v;
         default: ;
      endcase
   endtask

   function automatic logic [7:0] exp_rd(input logic [7:0] a);
      logic [15:0] view;
      view = (m_dir & (pad_in ^ m_inv)) | (~m_dir & m_lat);
      case (a)
         8'h07: return m_pu[7:0];   8'h06: return m_pu[15:8];
         8'h09: return m_pd[7:0];   8'h08: return m_pd[15:8];
         8'h0B: return m_od[7:0];   8'h0A: return m_od[15:8];
         8'h0D: return m_inv[7:0];  8'h0C: return m_inv[15:8];
         8'h0F: return m_dir[7:0];  8'h0E: return m_dir[15:8];
         8'h11: return view[7:0];   8'h10: return view[15:8];
         8'h1F: return m_misc;
         default: return 8'h00;
      endcase
   endfunction

   task automatic bus_write(input logic [7:0] a, input logic [7:0] v);
      @(negedge clk); addr = a; wdata = v; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0; v = rdata;
   endtask

   task automatic check_pads(input string tag);
      check({tag, " R3 pad_pu"}, pad_pu, m_pu);
      check({tag, " R3 pad_pd"}, pad_pd, m_pd);
      check({tag, " R4/R5 pad_oe"}, pad_oe, ~m_dir & ~(m_od & m_lat));
      check({tag, " R4/R5 pad_out"}, pad_out, m_lat & ~m_od);
   endtask

   task automatic check_all_reads(input string tag);
      logic [7:0] v;
      for (int a = 0; a < 256; a++) begin
         bus_read(8'(a), v);
         check($sformatf("%s R1/R6/R8/R11 read 0x%02h", tag, a), {8'h00, v}, {8'h00, exp_rd(8'(a))});
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      model_defaults();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      check("R2 rdata after reset", {8'h00, rdata}, 16'h0000);
      check_pads("R2 reset");
      check_all_reads("R2");

      // R1 R3 R4 R5 R6 R8 R11: sweeps over every address with several patterns
      for (int p = 0; p < 4; p++) begin
         pad_in = 16'(p * 16'h3A5C + 16'h0F0F);
         for (int a = 0; a < 256; a++) begin
            if (a == 8'h7D) continue;
            bus_write(8'(a), 8'(a * 37 + p * 91 + 5));
            model_wr(8'(a), 8'(a * 37 + p * 91 + 5));
         end
         check_pads($sformatf("sweep %0d", p));
         check_all_reads($sformatf("sweep %0d", p));
      end

      // R8 misc accepts 0x01
      bus_write(8'h1F, 8'h01); model_wr(8'h1F, 8'h01);
      bus_read(8'h1F, v);
      check("R8 misc 0x01", {8'h00, v}, 16'h0001);

      // R6 input inversion over pad patterns, all inputs
      bus_write(8'h0F, 8'hFF); model_wr(8'h0F, 8'hFF);
      bus_write(8'h0E, 8'hFF); model_wr(8'h0E, 8'hFF);
      bus_write(8'h0D, 8'h0F); model_wr(8'h0D, 8'h0F);
      bus_write(8'h0C, 8'hF0); model_wr(8'h0C, 8'hF0);
      for (int j = 0; j < 8; j++) begin
         @(negedge clk); pad_in = 16'(j * 16'h2493 + 16'h8001);
         repeat (SYNC) @(negedge clk);
         bus_read(8'h11, v);
         check("R6 data low byte", {8'h00, v}, {8'h00, pad_in[7:0] ^ 8'h0F});
         bus_read(8'h10, v);
         check("R6 data high byte", {8'h00, v}, {8'h00, pad_in[15:8] ^ 8'hF0});
      end

      // R5 open-drain pins: latch 1 releases, latch 0 drives low
      bus_write(8'h0B, 8'hFF); model_wr(8'h0B, 8'hFF);
      bus_write(8'h0F, 8'h00); model_wr(8'h0F, 8'h00);
      bus_write(8'h11, 8'hA5); model_wr(8'h11, 8'hA5);
      check("R5 od oe", {8'h00, pad_oe[7:0]}, 16'h005A);
      check("R5 od out", {8'h00, pad_out[7:0]}, 16'h0000);

      // R7 hold while no read strobe
      bus_read(8'h0B, v);
      addr = 8'h11;
      repeat (4) @(negedge clk);
      check("R7 rdata held", {8'h00, rdata}, 16'h00FF);

      // R10 key broken by an intervening write, which still lands
      bus_write(8'h7D, 8'h12);
      bus_write(8'h07, 8'h55); model_wr(8'h07, 8'h55);
      bus_write(8'h7D, 8'h34);
      check_pads("R10 intervening write");
      // R10 wrong second value
      bus_write(8'h7D, 8'h12);
      bus_write(8'h7D, 8'h35);
      check_pads("R10 wrong value");
      // R10 wrong first value
      bus_write(8'h7D, 8'h13);
      bus_write(8'h7D, 8'h34);
      check_pads("R10 wrong first");
      bus_read(8'h07, v);
      check("R10 pull-up kept", {8'h00, v}, 16'h0055);

      // R9 valid key with idle cycles between the two writes
      bus_write(8'h7D, 8'h12);
      repeat (3) @(negedge clk);
      bus_write(8'h7D, 8'h34);
      model_defaults();
      check_pads("R9 key reset");
      check_all_reads("R9");

      // R11 write to unmapped addresses leaves state untouched
      bus_write(8'h20, 8'hFF);
      bus_write(8'h05, 8'hFF);
      check_pads("R11 unmapped write");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
   end
endmodule